// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block collects a fixed set of level-sensitive interrupt inputs and gates each through enable fields held in a small register file. Enable fields come in two kinds. A mask register holds one bit per field and is written through a pair of addresses: one that sets bits and one that clears them. A priority register holds multi-bit fields and counts any nonzero field as an enable. A field can also name a group instead of one source. Clearing a group field disables every member of that group.

A source is pending only while its input is high and every field that names it, directly or through a group, is on. The block raises one combined request to the processor while any source is pending. When the processor presents its current mask level, a small state machine scans the sources from index 0 upward. It returns the vector code of the first pending source, or a reply with no vector when none is found or the mask level is 15.

The scan machine has four states. SC_IDLE waits for a request. A request with mask level 15 moves it to SC_MISS, and any other request moves it to SC_SCAN starting at index 0. In SC_SCAN it tests one source per cycle. A pending source moves it to SC_HIT. Reaching the last index with nothing pending moves it to SC_MISS; otherwise the index advances. SC_HIT and SC_MISS each last one cycle, raise `vec_done`, and then return to SC_IDLE.

Top module: `intc_setclr_top`

## Requirements
- R1: A source is pending only when its level input is 1 and every enable field that names it is on. A mask field is on when its bit is 1. A priority field is on when its value is nonzero. A source with a zero priority field stays blocked even when its mask bit is set.
- R2: `cpu_irq` is 1 in the cycle after at least one source is pending, and 0 in the cycle after none is pending.
- R3: A write to the set address of a mask register stores the old value OR the low MW bits of the write data.
- R4: A write to the clear address of a mask register stores the old value AND NOT the low MW bits of the write data.
- R5: In a mask register, the top bit (bit MW-1) is field 0 and lower bits follow in field order. With the defaults, register 0 bit 7 enables source 0 and bit 6 enables source 1.
- R6: A priority register holds PW/FW fields of FW bits, with field 0 in the top bits. A write stores the data as given. With the defaults, bits 15:12 enable source 0, bits 11:8 enable source 1 and bits 7:4 enable group 0. Changing a field from one nonzero value to another leaves the enable unchanged.
- R7: Addresses are compared on bits 28:0 only. Mask register r answers at MASK_BASE+8r (set) and MASK_BASE+8r+4 (clear). Priority register j answers at PRIO_BASE+4j. Any values of bits 31:29 reach the same register.
- R8: A vector request with a mask level below 15 returns the code VEC_BASE+VEC_STEP*i, with `vec_valid` high, for the lowest index i that is pending.
- R9: A vector request with mask level 15 returns a reply with `vec_valid` low, even when sources are pending.
- R10: A field whose id names a group gates every member source listed in GRP_MEMBERS. With the defaults, mask register 1 bit 7 and priority bits 7:4 gate sources 4 and 5, and mask register 1 bit 6 gates sources 6 and 7.
- R11: A read at either the set or the clear address of a register returns its stored value, zero-extended, on `bus_rdata` in the cycle after `bus_rd`.
- R12: Every reply is a single-cycle `vec_done` pulse. `vec_valid` is high only together with `vec_done`, and it is low when no source is pending.
- R13: After reset, all mask and priority registers are 0, `cpu_irq` is 0, and a vector request returns no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | NSRC | Level input of each source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_rd` |
| cpu_irq | output | 1 | Combined interrupt request |
| vec_req | input | 1 | Vector request pulse, accepted in SC_IDLE |
| vec_imask | input | 4 | Current processor mask level |
| vec_done | output | 1 | One-cycle reply strobe |
| vec_valid | output | 1 | Reply carries a vector |
| vec_code | output | VW | Vector code of the chosen source |

## Verification
The bench first sets a mask bit while leaving the source's priority field at zero. A design that treated any single enable as enough would raise the request at this point. It then moves a priority value from field 0 into field 1 and checks which source wakes, which catches a design that numbers fields from the bottom. The same check on a mask register catches a design whose bit order starts at bit 0. With two sources pending, the bench checks that the lower index wins and that mask level 15 suppresses the vector. A scan that started at the top index, or that ignored the mask level, would return the wrong reply. Group sources are opened one field at a time, including through aliased addresses. An unmasked group field, a missing alias, or a clear that acted as a set would each leave the request level or a read-back value wrong.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_HIT  = 2'd2,
        SC_MISS = 2'd3
    } scan_state_t;

    localparam logic [3:0] IMASK_ALL = 4'hF;

    // Address bits that take part in register decode
    function automatic logic [28:0] addr_key(input logic [31:0] a);
        return a[28:0];
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          NMASK     = 2,
    parameter int          MW        = 8,
    parameter int          NPRIO     = 1,
    parameter int          PW        = 16,
    parameter logic [31:0] MASK_BASE = 32'hA400_0040,
    parameter logic [31:0] PRIO_BASE = 32'hA400_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [NMASK*MW-1:0] mask_flat,
    output logic [NPRIO*PW-1:0] prio_flat
);

    logic [28:0]   key;
    logic [DW-1:0] rd_next;
    logic [DW-1:0] rdata_q;

    assign key = addr_key(bus_addr);

    for (genvar r = 0; r < NMASK; r++) begin : g_mask
        localparam logic [31:0] SET_A = MASK_BASE + 32'(8 * r);
        localparam logic [31:0] CLR_A = MASK_BASE + 32'(8 * r + 4);
        logic [MW-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (bus_wr && key == addr_key(SET_A)) begin
                val_q <= val_q | bus_wdata[MW-1:0];
            end else if (bus_wr && key == addr_key(CLR_A)) begin
                val_q <= val_q & ~bus_wdata[MW-1:0];
            end
        end

        assign mask_flat[r*MW +: MW] = val_q;
    end

    for (genvar j = 0; j < NPRIO; j++) begin : g_prio
        localparam logic [31:0] PRI_A = PRIO_BASE + 32'(4 * j);
        logic [PW-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (bus_wr && key == addr_key(PRI_A)) begin
                val_q <= bus_wdata[PW-1:0];
            end
        end

        assign prio_flat[j*PW +: PW] = val_q;
    end

    always_comb begin
        rd_next = '0;
        for (int r = 0; r < NMASK; r++) begin
            if (key == addr_key(MASK_BASE + 32'(8 * r)) ||
                key == addr_key(MASK_BASE + 32'(8 * r + 4))) begin
                rd_next = DW'(mask_flat[r*MW +: MW]);
            end
        end
        for (int j = 0; j < NPRIO; j++) begin
            if (key == addr_key(PRIO_BASE + 32'(4 * j))) begin
                rd_next = DW'(prio_flat[j*PW +: PW]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/intc_enable_map.sv
module intc_enable_map #(
    parameter int                          NSRC        = 8,
    parameter int                          NGRP        = 2,
    parameter int                          IDW         = 4,
    parameter int                          NMASK       = 2,
    parameter int                          MW          = 8,
    parameter int                          NPRIO       = 1,
    parameter int                          PW          = 16,
    parameter int                          FW          = 4,
    parameter logic [NMASK*MW*IDW-1:0]     MASK_IDS    = 64'h0000_00A9_8765_4321,
    parameter logic [NPRIO*(PW/FW)*IDW-1:0] PRIO_IDS   = 16'h0921,
    parameter logic [NGRP*NSRC-1:0]        GRP_MEMBERS = 16'hC030
) (
    input  logic [NMASK*MW-1:0] mask_flat,
    input  logic [NPRIO*PW-1:0] prio_flat,
    output logic [NSRC-1:0]     src_en
);

    localparam int NPF = PW / FW;

    // Field id 0 = unused, 1..NSRC = source, above that = group
    function automatic logic targets(input int id, input int s);
        if (id == s + 1) begin
            return 1'b1;
        end
        if (id > NSRC && id <= NSRC + NGRP) begin
            return GRP_MEMBERS[(id - NSRC - 1) * NSRC + s];
        end
        return 1'b0;
    endfunction

    logic [NMASK*MW-1:0]  mask_on;
    logic [NPRIO*NPF-1:0] prio_on;

    for (genvar r = 0; r < NMASK; r++) begin : g_mfield
        for (genvar k = 0; k < MW; k++) begin : g_bit
            assign mask_on[r*MW + k] = mask_flat[r*MW + (MW - 1 - k)];
        end
    end

    for (genvar j = 0; j < NPRIO; j++) begin : g_pfield
        for (genvar k = 0; k < NPF; k++) begin : g_fld
            assign prio_on[j*NPF + k] = |prio_flat[j*PW + (NPF - 1 - k)*FW +: FW];
        end
    end

    always_comb begin
        src_en = '1;
        for (int f = 0; f < NMASK * MW; f++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (!mask_on[f] && targets(int'(MASK_IDS[f*IDW +: IDW]), s)) begin
                    src_en[s] = 1'b0;
                end
            end
        end
        for (int f = 0; f < NPRIO * NPF; f++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (!prio_on[f] && targets(int'(PRIO_IDS[f*IDW +: IDW]), s)) begin
                    src_en[s] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/intc_vec_scan.sv
module intc_vec_scan
    import intc_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int VW       = 12,
    parameter int VEC_BASE = 'h400,
    parameter int VEC_STEP = 'h020
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic            req,
    input  logic [3:0]      imask,
    output logic            busy,
    output logic            done,
    output logic            valid,
    output logic [VW-1:0]   code
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    scan_state_t    state_q, state_d;
    logic [IW-1:0]  idx_q;
    logic [VW-1:0]  code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: begin
                if (req) begin
                    state_d = (imask == IMASK_ALL) ? SC_MISS : SC_SCAN;
                end
            end
            SC_SCAN: begin
                if (pend[idx_q]) begin
                    state_d = SC_HIT;
                end else if (idx_q == IW'(NSRC - 1)) begin
                    state_d = SC_MISS;
                end
            end
            SC_HIT:  state_d = SC_IDLE;
            SC_MISS: state_d = SC_IDLE;
            default: state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_IDLE;
            idx_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SC_SCAN) begin
                idx_q <= idx_q + 1'b1;
                if (pend[idx_q]) begin
                    code_q <= VW'(VEC_BASE + VEC_STEP * int'(idx_q));
                end
            end else begin
                idx_q <= '0;
            end
        end
    end

    always_comb begin
        busy  = 1'b1;
        done  = 1'b0;
        valid = 1'b0;
        unique case (state_q)
            SC_IDLE: busy = 1'b0;
            SC_SCAN: ;
            SC_HIT: begin
                done  = 1'b1;
                valid = 1'b1;
            end
            SC_MISS: done = 1'b1;
            default: ;
        endcase
    end

    assign code = code_q;

endmodule

// File: rtl/intc_setclr_top.sv
module intc_setclr_top
    import intc_pkg::*;
#(
    parameter int                           NSRC        = 8,
    parameter int                           NGRP        = 2,
    parameter int                           IDW         = 4,
    parameter int                           DW          = 32,
    parameter int                           NMASK       = 2,
    parameter int                           MW          = 8,
    parameter int                           NPRIO       = 1,
    parameter int                           PW          = 16,
    parameter int                           FW          = 4,
    parameter int                           VW          = 12,
    parameter int                           VEC_BASE    = 'h400,
    parameter int                           VEC_STEP    = 'h020,
    parameter logic [31:0]                  MASK_BASE   = 32'hA400_0040,
    parameter logic [31:0]                  PRIO_BASE   = 32'hA400_0000,
    parameter logic [NMASK*MW*IDW-1:0]      MASK_IDS    = 64'h0000_00A9_8765_4321,
    parameter logic [NPRIO*(PW/FW)*IDW-1:0] PRIO_IDS    = 16'h0921,
    parameter logic [NGRP*NSRC-1:0]         GRP_MEMBERS = 16'hC030
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [31:0]     bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            cpu_irq,
    input  logic            vec_req,
    input  logic [3:0]      vec_imask,
    output logic            vec_done,
    output logic            vec_valid,
    output logic [VW-1:0]   vec_code
);

    logic [NMASK*MW-1:0] mask_flat;
    logic [NPRIO*PW-1:0] prio_flat;
    logic [NSRC-1:0]     src_en;
    logic [NSRC-1:0]     pend;
    logic                scan_busy;
    logic                irq_q;

    intc_regfile #(
        .DW(DW), .NMASK(NMASK), .MW(MW), .NPRIO(NPRIO), .PW(PW),
        .MASK_BASE(MASK_BASE), .PRIO_BASE(PRIO_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_flat (mask_flat),
        .prio_flat (prio_flat)
    );

    intc_enable_map #(
        .NSRC(NSRC), .NGRP(NGRP), .IDW(IDW), .NMASK(NMASK), .MW(MW),
        .NPRIO(NPRIO), .PW(PW), .FW(FW),
        .MASK_IDS(MASK_IDS), .PRIO_IDS(PRIO_IDS), .GRP_MEMBERS(GRP_MEMBERS)
    ) u_emap (
        .mask_flat (mask_flat),
        .prio_flat (prio_flat),
        .src_en    (src_en)
    );

    assign pend = src_lvl & src_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pend;
        end
    end

    assign cpu_irq = irq_q;

    intc_vec_scan #(
        .NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .req   (vec_req),
        .imask (vec_imask),
        .busy  (scan_busy),
        .done  (vec_done),
        .valid (vec_valid),
        .code  (vec_code)
    );

endmodule

// File: rtl/intc_setclr_checker.sv
module intc_setclr_checker
    import intc_pkg::*;
#(
    parameter int          NSRC      = 8,
    parameter int          DW        = 32,
    parameter int          MW        = 8,
    parameter logic [31:0] MASK_BASE = 32'hA400_0040
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_lvl,
    input logic [NSRC-1:0] pend,
    input logic            cpu_irq,
    input logic            bus_wr,
    input logic [31:0]     bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [MW-1:0]   mask0,
    input logic            vec_req,
    input logic [3:0]      vec_imask,
    input logic            scan_busy,
    input logic            vec_done,
    input logic            vec_valid
);

    // R1: nothing is pending without its level input
    assert_pend_needs_level_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(pend & ~src_lvl) == 0);

    // R2: request follows the pending set one cycle later
    assert_irq_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> cpu_irq);
    assert_irq_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !cpu_irq);

    // R3: set address ORs into mask register 0
    assert_set_or_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_key(bus_addr) == addr_key(MASK_BASE))
        |=> mask0 == ($past(mask0) | $past(bus_wdata[MW-1:0])));

    // R4: clear address ANDs the complement into mask register 0
    assert_clr_andnot_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_key(bus_addr) == addr_key(MASK_BASE + 32'd4))
        |=> mask0 == ($past(mask0) & ~$past(bus_wdata[MW-1:0])));

    // R9: full mask level gets an empty reply next cycle
    assert_full_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !scan_busy && vec_imask == IMASK_ALL) |=> (vec_done && !vec_valid));

    // R12: valid only with done, done is one cycle wide
    assert_valid_in_done_R12: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> vec_done);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        vec_done |=> !vec_done);

endmodule

bind intc_setclr_top intc_setclr_checker #(
    .NSRC(NSRC), .DW(DW), .MW(MW), .MASK_BASE(MASK_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_lvl   (src_lvl),
    .pend      (pend),
    .cpu_irq   (cpu_irq),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask0     (mask_flat[MW-1:0]),
    .vec_req   (vec_req),
    .vec_imask (vec_imask),
    .scan_busy (scan_busy),
    .vec_done  (vec_done),
    .vec_valid (vec_valid)
);

// File: tb/tb_intc_setclr_top.sv
`timescale 1ns/1ps
module tb_intc_setclr_top;

    localparam logic [31:0] MS0 = 32'hA400_0040;
    localparam logic [31:0] MC0 = 32'hA400_0044;
    localparam logic [31:0] MS1 = 32'hA400_0048;
    localparam logic [31:0] MC1 = 32'hA400_004C;
    localparam logic [31:0] PR0 = 32'hA400_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    logic        vec_req = 1'b0;
    logic [3:0]  vec_imask = '0;
    logic        vec_done;
    logic        vec_valid;
    logic [11:0] vec_code;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        valid;
        logic [11:0] code;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    intc_setclr_top dut (
        .clk(clk), .rst(rst), .src_lvl(src_lvl),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
        .vec_req(vec_req), .vec_imask(vec_imask), .vec_done(vec_done),
        .vec_valid(vec_valid), .vec_code(vec_code)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        chk(cpu_irq == exp, tag, 32'(cpu_irq), 32'(exp));
    endtask

    // Driver: queue the expected reply, then issue the request
    task automatic vec_ask(input logic [3:0] im, input logic ev, input logic [11:0] ec,
                           input string tag);
        exp_t e;
        e.valid = ev; e.code = ec; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        vec_req = 1'b1; vec_imask = im;
        @(negedge clk);
        vec_req = 1'b0;
        while (!vec_done) @(negedge clk);
    endtask

    // Monitor: compare each reply with the head of the queue
    always @(negedge clk) begin
        if (!rst && vec_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R12 unexpected reply", 32'(vec_code), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.valid) begin
                    chk(vec_valid && vec_code == e.code, e.tag,
                        {19'b0, vec_valid, vec_code}, {20'h00001, e.code});
                end else begin
                    chk(!vec_valid, e.tag, 32'(vec_valid), 32'h0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_irq == 1'b0, "R13 irq after reset", 32'(cpu_irq), 32'h0);
        rd_chk(MS0, 32'h0, "R13 mask reg reset");
        rd_chk(PR0, 32'h0, "R13 prio reg reset");
        vec_ask(4'h0, 1'b0, 12'h0, "R13 no vector after reset");

        src_lvl = 8'h01;
        wr(MS0, 32'h80);
        irq_chk(1'b0, "R1 zero prio field blocks source 0");
        rd_chk(MC0, 32'h80, "R11 read at clear address");
        wr(PR0, 32'h3000);
        irq_chk(1'b1, "R1 R2 all enables on raise irq");
        vec_ask(4'h0, 1'b1, 12'h400, "R8 vector of source 0");
        wr(PR0, 32'h7000);
        irq_chk(1'b1, "R6 nonzero to nonzero keeps enable");
        wr(PR0, 32'h0300);
        irq_chk(1'b0, "R6 field 0 is top nibble, R2 falls");
        rd_chk(PR0, 32'h0300, "R11 prio read back");

        wr(MS0, 32'h40);
        rd_chk(MS0, 32'hC0, "R3 set ORs");
        wr(MC0, 32'h80);
        rd_chk(MS0, 32'h40, "R4 clear ANDs complement");

        src_lvl = 8'h03;
        irq_chk(1'b1, "R5 bit 6 enables source 1");
        vec_ask(4'h0, 1'b1, 12'h420, "R5 source 1 chosen, source 0 masked");

        wr(PR0, 32'h1300);
        wr(MS0, 32'h80);
        vec_ask(4'h0, 1'b1, 12'h400, "R8 lowest index wins");
        vec_ask(4'hF, 1'b0, 12'h0, "R9 mask level 15 blocks");
        vec_ask(4'hE, 1'b1, 12'h400, "R9 mask level 14 allowed");

        src_lvl = 8'h10;
        wr(MC0, 32'hC0);
        wr(MS0, 32'h08);
        irq_chk(1'b0, "R10 group mask field off blocks source 4");
        wr(MS1, 32'h80);
        irq_chk(1'b0, "R10 group prio field zero blocks source 4");
        wr(PR0, 32'h0050);
        irq_chk(1'b1, "R10 group fields on enable source 4");
        vec_ask(4'h0, 1'b1, 12'h480, "R10 vector of source 4");
        wr(MC1, 32'h80);
        irq_chk(1'b0, "R10 clearing group field masks source 4");

        src_lvl = 8'h20;
        wr(32'hE400_0040, 32'h04);
        wr(32'h0400_0048, 32'h80);
        irq_chk(1'b1, "R7 R10 alias writes enable source 5");
        vec_ask(4'h0, 1'b1, 12'h4A0, "R10 vector of source 5");
        rd_chk(32'h2400_0040, 32'h0C, "R7 alias read");

        src_lvl = 8'h80;
        wr(MS0, 32'h01);
        irq_chk(1'b0, "R10 group 1 field off blocks source 7");
        vec_ask(4'h0, 1'b0, 12'h0, "R12 no pending gives no vector");
        wr(MS1, 32'h40);
        irq_chk(1'b1, "R10 group 1 field on enables source 7");
        vec_ask(4'h3, 1'b1, 12'h4E0, "R10 vector of source 7");

        src_lvl = 8'h00;
        irq_chk(1'b0, "R2 irq falls with levels low");
        @(negedge clk);
        chk(sb_q.size() == 0, "R12 all replies seen", 32'(sb_q.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule